// File: doc/BRIEF.md
# SPI Transmit Queue Status Unit

This block holds the bytes waiting to be sent on an SPI port and keeps the flags that report on them. The bus side pushes bytes into a small queue. The serial shifter takes the oldest byte each time it starts a transfer. A status word shows how many bytes are queued, together with three sticky flags:

- **done**: the programmed number of bytes has gone out.
- **underflow**: a transfer started while the queue was empty.
- **summary**: some interrupt condition has occurred.

Reading the status word clears the sticky flags. A half-word mode, meant for DMA traffic, pushes two bytes per write. A flush control empties the queue at once. While flush is high it also hides the underflow condition from the interrupt.

The shifter drives `xfer_start` for one cycle per byte. In the same cycle it takes `pop_data` if `pop_valid` is high. Software, or a DMA engine, drives `wr_en`/`wr_data`, and pulses `stat_rd` when it samples `status`.

Top module: `spi_txq_status`

## Requirements
- R1: After reset the level field `status[2:0]` is 0 and the flags `status[3]` (done), `status[4]` (underflow) and `status[5]` (summary) are all 0. `irq` is 0.
- R2: The queue holds at most 4 bytes and returns them in first-in, first-out order. `status[2:0]` gives the byte count from 0 to 4. A byte written when no space is left is dropped and the count stays at 4.
- R3: When `xfer_start` is high and the queue is not empty, `pop_valid` is high in the same cycle and `pop_data` carries the oldest byte. The count drops by one on the next cycle. If `xfer_start` is high while the queue is empty, `pop_valid` stays 0 and `status[4]` is 1 from the next cycle.
- R4: With `dma_mode` high, a write queues `wr_data[7:0]` first and then `wr_data[15:8]`, each byte only while space remains. With `dma_mode` low, only `wr_data[7:0]` is queued and `wr_data[15:8]` is ignored. If a pop and a write occur in the same cycle, the pop frees its slot first.
- R5: While `flush` is high the count is 0 from the next cycle, and any write made in that cycle is dropped.
- R6: With `done_en` high and `dma_mode` low, each popped byte advances a sent count. `status[3]` sets on the cycle after the pop that brings the sent count to `done_target`, and the sent count then restarts. A `done_target` of 0 never sets it. `status[3]` never sets while `dma_mode` is high.
- R7: `stat_rd` returns the flag values as they were before the read, and clears `status[3]`, `status[4]` and `status[5]` on the next cycle.
- R8: If a flag-setting event and `stat_rd` fall in the same cycle, that flag is 1 on the next cycle.
- R9: `status[5]` sets on a done event, and on an underflow event that happens while `flush` is low. `irq` equals `status[3]` OR (`status[4]` AND NOT `flush`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_mode | input | 1 | Half-word push mode; also blocks the done flag |
| wr_en | input | 1 | Push strobe from the bus side |
| wr_data | input | 16 | Push data; low byte goes first |
| flush | input | 1 | Empty the queue; masks the underflow interrupt |
| xfer_start | input | 1 | Shifter starts a byte transfer |
| pop_valid | output | 1 | A byte is handed to the shifter this cycle |
| pop_data | output | 8 | Oldest queued byte |
| done_en | input | 1 | Enables counting toward the done flag |
| done_target | input | 3 | Bytes per done event; 0 disables the flag |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| status | output | 6 | {summary, underflow, done, level[2:0]} |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a flag-setting event (a done pop or an underflow start), and a status read that clears the flags. The same holds for a pop and a push against a nearly full queue. Directed steps place `stat_rd` on the exact cycle of an empty-queue `xfer_start`, and on the exact cycle of the target-reaching pop. They then check that the flag is still 1 one cycle later. A long stretch of mixed random stimulus is also compared, cycle by cycle, against a queue-based reference model. In that model, the event is applied after the clear and the pop is applied before the push.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
    // Status word positions above the level field (relative to level width)
    localparam int FLAG_DONE_OFS = 0;
    localparam int FLAG_UNF_OFS  = 1;
    localparam int FLAG_SUM_OFS  = 2;
    localparam int FLAG_COUNT    = 3;

    typedef struct packed {
        logic done;
        logic unf;
        logic sum;
    } txq_flags_t;
endpackage

// File: rtl/spi_txq_fifo.sv
module spi_txq_fifo #(
    parameter int DEPTH = 4,
    parameter int BW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dma_mode,
    input  logic            wr_en,
    input  logic [2*BW-1:0] wr_data,
    input  logic            flush,
    input  logic            xfer_start,
    output logic            pop_valid,
    output logic [BW-1:0]   pop_data,
    output logic            unf_evt,
    output logic [CW-1:0]   level
);
    typedef struct packed {
        logic [DEPTH-1:0][BW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_valid = xfer_start && (st_q.cnt != '0);
    assign unf_evt   = xfer_start && (st_q.cnt == '0);
    assign pop_data  = st_q.mem[st_q.rd];
    assign level     = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (pop_valid) begin
                st_d.rd  = ptr_inc(st_q.rd);
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (wr_en && (st_d.cnt < CW'(DEPTH))) begin
                st_d.mem[st_d.wr] = wr_data[BW-1:0];
                st_d.wr           = ptr_inc(st_d.wr);
                st_d.cnt          = st_d.cnt + 1'b1;
            end
            if (wr_en && dma_mode && (st_d.cnt < CW'(DEPTH))) begin
                st_d.mem[st_d.wr] = wr_data[2*BW-1:BW];
                st_d.wr           = ptr_inc(st_d.wr);
                st_d.cnt          = st_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: occupancy never exceeds capacity
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R2: a full queue with no pop and no flush stays full
    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CW'(DEPTH) && !xfer_start && !flush) |=> (st_q.cnt == CW'(DEPTH)));
    // R5: flush empties the queue in one cycle
    a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0));
    // R3: a start on an empty queue hands out nothing
    a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |-> !pop_valid);
endmodule

// File: rtl/spi_txq_flags.sv
module spi_txq_flags #(
    parameter int CW = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pop_valid,
    input  logic                     unf_evt,
    input  logic                     dma_mode,
    input  logic                     done_en,
    input  logic [CW-1:0]            done_target,
    input  logic                     stat_rd,
    input  logic                     flush,
    output spi_txq_pkg::txq_flags_t  flags,
    output logic                     irq
);
    import spi_txq_pkg::*;

    typedef struct packed {
        logic [CW-1:0] sent;
        txq_flags_t    fl;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     counting;
    logic     done_evt;

    assign counting = pop_valid && done_en && !dma_mode;
    assign done_evt = counting && (done_target != '0) &&
                      ((st_q.sent + 1'b1) >= done_target);

    always_comb begin
        st_d = st_q;
        if (!done_en)
            st_d.sent = '0;
        else if (counting)
            st_d.sent = (done_evt || done_target == '0) ? '0 : st_q.sent + 1'b1;
        st_d.fl.done = done_evt | (st_q.fl.done & ~stat_rd);
        st_d.fl.unf  = unf_evt  | (st_q.fl.unf  & ~stat_rd);
        st_d.fl.sum  = done_evt | (unf_evt & ~flush) | (st_q.fl.sum & ~stat_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.fl;
    assign irq   = st_q.fl.done | (st_q.fl.unf & ~flush);

    // R7: a read with no new event clears every sticky flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !done_evt && !unf_evt) |=> (st_q.fl == '0));
    // R8: an underflow event is never lost to a same-cycle read
    a_r8_unf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> st_q.fl.unf);
    // R6: done never rises while half-word mode was active
    a_r6_no_done_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && !st_q.fl.done) |=> !st_q.fl.done);
    // R9: the summary flag rises only with a done or underflow event
    a_r9_sum_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fl.sum) |-> ($past(done_evt) || $past(unf_evt)));
endmodule

// File: rtl/spi_txq_status.sv
module spi_txq_status #(
    parameter int DEPTH = 4,
    parameter int BW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int SW   = CW + spi_txq_pkg::FLAG_COUNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dma_mode,
    input  logic            wr_en,
    input  logic [2*BW-1:0] wr_data,
    input  logic            flush,
    input  logic            xfer_start,
    output logic            pop_valid,
    output logic [BW-1:0]   pop_data,
    input  logic            done_en,
    input  logic [CW-1:0]   done_target,
    input  logic            stat_rd,
    output logic [SW-1:0]   status,
    output logic            irq
);
    import spi_txq_pkg::*;

    logic          unf_evt;
    logic [CW-1:0] level;
    txq_flags_t    flags;

    spi_txq_fifo #(.DEPTH(DEPTH), .BW(BW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_mode   (dma_mode),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .flush      (flush),
        .xfer_start (xfer_start),
        .pop_valid  (pop_valid),
        .pop_data   (pop_data),
        .unf_evt    (unf_evt),
        .level      (level)
    );

    spi_txq_flags #(.CW(CW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_valid   (pop_valid),
        .unf_evt     (unf_evt),
        .dma_mode    (dma_mode),
        .done_en     (done_en),
        .done_target (done_target),
        .stat_rd     (stat_rd),
        .flush       (flush),
        .flags       (flags),
        .irq         (irq)
    );

    always_comb begin
        status                     = '0;
        status[CW-1:0]             = level;
        status[CW + FLAG_DONE_OFS] = flags.done;
        status[CW + FLAG_UNF_OFS]  = flags.unf;
        status[CW + FLAG_SUM_OFS]  = flags.sum;
    end

    // R9: the interrupt is raised only by a sticky flag
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags.done || flags.unf));
endmodule

// File: tb/sim_spi_txq_status.sv
module sim_spi_txq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_mode = 1'b0, wr_en = 1'b0, flush = 1'b0, xfer_start = 1'b0;
    logic        done_en = 1'b0, stat_rd = 1'b0;
    logic [15:0] wr_data = '0;
    logic [2:0]  done_target = '0;
    logic        pop_valid, irq;
    logic [7:0]  pop_data;
    logic [5:0]  status;

    always #5 clk = ~clk;

    spi_txq_status u0 (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .wr_en(wr_en),
        .wr_data(wr_data), .flush(flush), .xfer_start(xfer_start),
        .pop_valid(pop_valid), .pop_data(pop_data), .done_en(done_en),
        .done_target(done_target), .stat_rd(stat_rd), .status(status), .irq(irq)
    );

    int total = 0, fails = 0, cycles = 0;
    bit finished = 0;

    // reference model
    logic [7:0] q[$];
    int  sent = 0;
    bit  m_done = 0, m_unf = 0, m_sum = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        bit pv = xfer_start && q.size() > 0;
        chk("R2 level", 32'(status[2:0]), 32'(q.size()));
        chk("R6 done flag", 32'(status[3]), 32'(m_done));
        chk("R3 underflow flag", 32'(status[4]), 32'(m_unf));
        chk("R9 summary flag", 32'(status[5]), 32'(m_sum));
        chk("R9 irq", 32'(irq), 32'(m_done | (m_unf & ~flush)));
        chk("R3 pop_valid", 32'(pop_valid), 32'(pv));
        if (pv) chk("R3 pop_data", 32'(pop_data), 32'(q[0]));
    endtask

    task automatic model_update();
        bit pv   = xfer_start && q.size() > 0;
        bit uevt = xfer_start && q.size() == 0;
        bit cnt  = pv && done_en && !dma_mode;
        bit devt = cnt && done_target != 0 && (sent + 1 >= int'(done_target));
        if (!done_en) sent = 0;
        else if (cnt) sent = (devt || done_target == 0) ? 0 : sent + 1;
        if (flush) q.delete();
        else begin
            if (pv) void'(q.pop_front());
            if (wr_en) begin
                if (q.size() < 4) q.push_back(wr_data[7:0]);
                if (dma_mode && q.size() < 4) q.push_back(wr_data[15:8]);
            end
        end
        m_done = devt | (m_done & ~stat_rd);
        m_unf  = uevt | (m_unf & ~stat_rd);
        m_sum  = devt | (uevt & ~flush) | (m_sum & ~stat_rd);
    endtask

    // drive inputs after a falling edge, check, then advance one clock
    task automatic step(bit w, logic [15:0] d, bit dm, bit st, bit fl, bit de,
                        logic [2:0] tg, bit rd);
        wr_en = w; wr_data = d; dma_mode = dm; xfer_start = st; flush = fl;
        done_en = de; done_target = tg; stat_rd = rd;
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 16'h0, 0, 0, 0, 0, 3'd0, 0);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; total++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 status after reset", 32'(status), 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: fill past capacity, byte mode, upper byte ignored (R4)
        for (int i = 0; i < 6; i++) step(1, {8'hEE, 8'(8'h10 + i)}, 0, 0, 0, 0, 3'd0, 0);
        chk("R2 saturate at 4", 32'(status[2:0]), 32'd4);
        for (int i = 0; i < 4; i++) begin
            #1 xfer_start = 1;
            #0;
            #0;
            chk("R2 fifo order", 32'(pop_data), 32'(8'h10 + i));
            xfer_start = 0;
            step(0, 16'h0, 0, 1, 0, 0, 3'd0, 0);
        end

        // R8: underflow start in the same cycle as a status read
        step(0, 16'h0, 0, 1, 0, 0, 3'd0, 1);
        chk("R8 underflow kept through read", 32'(status[4]), 32'd1);
        chk("R9 summary after underflow", 32'(status[5]), 32'd1);
        // R7: a read clears on the following cycle
        step(0, 16'h0, 0, 0, 0, 0, 3'd0, 1);
        chk("R7 flags cleared", 32'(status[5:3]), 32'd0);

        // R4: half-word order, low byte first
        step(1, 16'hBBAA, 1, 0, 0, 0, 3'd0, 0);
        chk("R4 two bytes queued", 32'(status[2:0]), 32'd2);
        #1 xfer_start = 1; dma_mode = 1;
        #1 chk("R4 low byte first", 32'(pop_data), 32'hAA);
        step(0, 16'h0, 1, 1, 0, 0, 3'd0, 0);
        #1 xfer_start = 1; dma_mode = 1;
        #1 chk("R4 high byte second", 32'(pop_data), 32'hBB);
        step(0, 16'h0, 1, 1, 0, 0, 3'd0, 0);

        // R6: target of 2, done flag raised with a same-cycle read (R8)
        step(1, 16'h0201, 1, 0, 0, 1, 3'd2, 0);
        step(0, 16'h0, 0, 1, 0, 1, 3'd2, 0);
        chk("R6 no done after one byte", 32'(status[3]), 32'd0);
        step(0, 16'h0, 0, 1, 0, 1, 3'd2, 1);
        chk("R6 done after target bytes", 32'(status[3]), 32'd1);
        chk("R8 done kept through read", 32'(irq), 32'd1);
        step(0, 16'h0, 0, 0, 0, 1, 3'd2, 1);

        // R6: no done in half-word mode
        step(1, 16'h0403, 1, 0, 0, 1, 3'd1, 0);
        step(0, 16'h0, 1, 1, 0, 1, 3'd1, 0);
        chk("R6 no done in dma mode", 32'(status[3]), 32'd0);

        // R5: flush with a simultaneous write; underflow masked from irq
        step(1, 16'h0055, 0, 0, 1, 0, 3'd0, 0);
        chk("R5 flush empties", 32'(status[2:0]), 32'd0);
        step(0, 16'h0, 0, 1, 1, 0, 3'd0, 0);
        #1 flush = 1;
        #1 chk("R9 irq masked by flush", 32'(irq), 32'd0);
        flush = 0;
        #1 chk("R9 irq after flush drops", 32'(irq), 32'd1);
        step(0, 16'h0, 0, 0, 0, 0, 3'd0, 1);

        // mixed stimulus against the model
        for (int i = 0; i < 2000; i++) begin
            int r = $urandom_range(0, 99);
            step(r < 45, 16'($urandom), r % 7 == 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 30) == 0, r % 5 != 0, 3'($urandom),
                 $urandom_range(0, 5) == 0);
        end
        idle();

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule